// File: doc/BRIEF.md
# Low-Power Wake and Check-in Controller

This block decides when a battery-powered node sleeps and when it wakes. Low-power operation is chosen once, by an enable input that is sampled while reset is held. If low-power operation is off, the block stays awake and ignores every other input. If it is on, the block comes out of reset asleep. While asleep it counts 5-second tick strobes against a programmed sleep length. It also watches eight pins, each selected by a mask bit, for a change in either direction.

When it wakes, the block raises a one-cycle request for a broadcast check-in packet. A separate packet builder sends that packet. The code that goes with the request says why the block woke: `0xC1` for a pin change and `0xC2` for an expired timer. The block then counts half-second strobes while it waits for the system controller to reply. If no reply comes, it requests the same check-in once more. If the second wait also ends with no reply, it goes back to sleep. A reply holds the block awake until a sleep-now command arrives. A sleep-now command returns the block to sleep from any awake state.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: When `lp_en_n` is low during reset, the block leaves reset asleep (`asleep`=1). When `lp_en_n` is high during reset, `asleep` stays 0 until the next reset, and no input causes a check-in request.
- R2: While asleep, the block counts `tick_5s` strobes. On the strobe that reaches `sleep_len`, it wakes. In the next cycle `checkin_req`=1 and `checkin_code`=0xC2. A `sleep_len` of 0 acts as 1.
- R3: `pins[7]` is pin A6 and `pins[6:0]` are pins B6..B0. `wake_mask` uses the same bit positions. Each pin passes through a two-flop synchronizer. A change of a masked pin away from its value at sleep entry raises `checkin_req` with code 0xC1 three cycles after the pin changes. Changes on unmasked pins are ignored.
- R4: If a pin wake and a timer expiry fall in the same cycle, the code is 0xC1.
- R5: `checkin_req` is high for exactly one cycle per request. `checkin_code` holds its value between requests. `asleep` is 0 whenever a request is raised.
- R6: After a wake, the block waits `wait_len` `tick_half` strobes (0 acts as 1). At the end of the first wait it raises a second request with the same code. At the end of the second wait it sets `asleep` to 1.
- R7: A `reply_rx` pulse during either wait cancels the timeout. The block then stays awake and raises no further request until `sleep_cmd`.
- R8: With low-power operation enabled, `sleep_cmd` in any awake state sets `asleep` in the next cycle. While asleep, `sleep_cmd` has no effect.
- R9: On every entry into sleep, the sleep count restarts from the full `sleep_len`, and the pin reference is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_en_n | input | 1 | Low during reset enables low-power operation |
| tick_5s | input | 1 | One-cycle strobe every 5 s |
| tick_half | input | 1 | One-cycle strobe every 0.5 s |
| pins | input | 8 | Watched pins: bit 7 = A6, bits 6..0 = B6..B0 |
| wake_mask | input | 8 | Per-pin wake enable |
| sleep_len | input | 16 | Sleep length in 5-s units |
| wait_len | input | 8 | Reply wait in half-second units, 1..128 |
| reply_rx | input | 1 | Reply from the system controller received |
| sleep_cmd | input | 1 | Sleep-now command decoded |
| asleep | output | 1 | Block is in sleep |
| checkin_req | output | 1 | One-cycle request to send a broadcast check-in |
| checkin_code | output | 8 | Check-in reason code (0xC1 pin, 0xC2 timer) |

## Verification
The assertions assume that `tick_5s`, `tick_half`, `reply_rx` and `sleep_cmd` are single-cycle strobes sampled on the clock. They also assume that `sleep_len`, `wait_len` and `wake_mask` stay stable while a count is running. The stimulus changes these settings only while the block is asleep, or just before an event that reloads them. It also holds `pins` steady through reset so the first reference is a settled value. Every pulse lasts exactly one clock and is driven between edges.

// File: rtl/lpw_pkg.sv
// Shared types and constants for the low-power wake controller.
package lpw_pkg;
    typedef enum logic [2:0] {
        ST_FULL  = 3'd0,   // low-power disabled, always awake
        ST_SLEEP = 3'd1,
        ST_WAIT1 = 3'd2,   // first check-in sent, awaiting reply
        ST_WAIT2 = 3'd3,   // retry sent, awaiting reply
        ST_HOLD  = 3'd4    // reply seen, awake until sleep command
    } lpw_state_t;

    localparam logic [7:0] CODE_PIN   = 8'hC1;
    localparam logic [7:0] CODE_TIMER = 8'hC2;
endpackage

// File: rtl/lpw_pin_watch.sv
// Pin watcher: two-flop synchronizer per pin, a reference captured on arm
// (and during reset), and a masked any-edge change flag.
// Assumes pins are held steady during reset; synchronizer flops carry no reset.
module lpw_pin_watch #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [NPIN-1:0] mask,
    input  logic            arm,
    output logic            change
);
    logic [NPIN-1:0] sync1, sync2, ref_q;

    // Synchronize the asynchronous pin inputs.
    always_ff @(posedge clk) begin
        sync1 <= pins;
        sync2 <= sync1;
    end

    // Capture the comparison reference on sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) ref_q <= sync2;
    end

    // Flag any masked pin that differs from its reference.
    always_comb change = |((sync2 ^ ref_q) & mask);
endmodule

// File: rtl/lpw_down_timer.sv
// Loadable down counter of external tick strobes. Expires on the tick that
// finds the count at 1 (or 0, so a zero length acts as one).
// Assumes load_val is stable while the count runs.
module lpw_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt;

    // Reload on request, otherwise count ticks down while running.
    always_ff @(posedge clk) begin
        if (!rst_n || load)                    cnt <= load_val;
        else if (run && tick && (cnt > ONE))   cnt <= cnt - ONE;
    end

    // Report expiry on the final tick.
    always_comb expire = run && tick && (cnt <= ONE);

    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !expire && !load) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/lpw_wake_ctrl.sv
// Low-power wake and check-in controller. Samples the enable at reset,
// sleeps until a masked pin changes or the sleep count ends, requests a
// reason-coded check-in, retries once after a half-second-tick wait, then
// sleeps again. A reply keeps it awake until a sleep command.
// Assumes tick, reply and command inputs are one-cycle synchronous strobes.
module lpw_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int NPIN   = 8,
    parameter int SLP_W  = 16,
    parameter int WAIT_W = 8,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_en_n,
    input  logic              tick_5s,
    input  logic              tick_half,
    input  logic [NPIN-1:0]   pins,
    input  logic [NPIN-1:0]   wake_mask,
    input  logic [SLP_W-1:0]  sleep_len,
    input  logic [WAIT_W-1:0] wait_len,
    input  logic              reply_rx,
    input  logic              sleep_cmd,
    output logic              asleep,
    output logic              checkin_req,
    output logic [CODE_W-1:0] checkin_code
);
    lpw_state_t        state, state_n;
    logic              lp_on;
    logic              req_q, req_n;
    logic [CODE_W-1:0] code_q, code_n;
    logic              go_sleep;
    logic              pin_change, sleep_exp, wait_exp;
    logic              waiting;

    always_comb waiting = (state == ST_WAIT1) || (state == ST_WAIT2);

    lpw_pin_watch #(.NPIN(NPIN)) u_pins (
        .clk(clk), .rst_n(rst_n), .pins(pins), .mask(wake_mask),
        .arm(go_sleep), .change(pin_change)
    );

    lpw_down_timer #(.W(SLP_W)) u_sleep_tmr (
        .clk(clk), .rst_n(rst_n), .load(go_sleep), .load_val(sleep_len),
        .run(state == ST_SLEEP), .tick(tick_5s), .expire(sleep_exp)
    );

    lpw_down_timer #(.W(WAIT_W)) u_wait_tmr (
        .clk(clk), .rst_n(rst_n), .load(req_n), .load_val(wait_len),
        .run(waiting), .tick(tick_half), .expire(wait_exp)
    );

    // Next-state, request and sleep-entry decisions.
    always_comb begin
        state_n  = state;
        req_n    = 1'b0;
        code_n   = code_q;
        go_sleep = 1'b0;
        unique case (state)
            ST_SLEEP: begin
                if (pin_change) begin
                    state_n = ST_WAIT1; req_n = 1'b1; code_n = CODE_PIN;
                end else if (sleep_exp) begin
                    state_n = ST_WAIT1; req_n = 1'b1; code_n = CODE_TIMER;
                end
            end
            ST_WAIT1: begin
                if (sleep_cmd)     go_sleep = 1'b1;
                else if (reply_rx) state_n  = ST_HOLD;
                else if (wait_exp) begin
                    state_n = ST_WAIT2; req_n = 1'b1;
                end
            end
            ST_WAIT2: begin
                if (sleep_cmd)     go_sleep = 1'b1;
                else if (reply_rx) state_n  = ST_HOLD;
                else if (wait_exp) go_sleep = 1'b1;
            end
            ST_HOLD: begin
                if (sleep_cmd)     go_sleep = 1'b1;
            end
            default: ;
        endcase
        if (go_sleep) state_n = ST_SLEEP;
    end

    // State register; the mode is chosen from the enable while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_on  <= ~lp_en_n;
            state  <= lp_en_n ? ST_FULL : ST_SLEEP;
            req_q  <= 1'b0;
            code_q <= '0;
        end else begin
            state  <= state_n;
            req_q  <= req_n;
            code_q <= code_n;
        end
    end

    // Drive outputs from registers.
    always_comb begin
        asleep       = (state == ST_SLEEP);
        checkin_req  = req_q;
        checkin_code = code_q;
    end

    a_r1_full_stays_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_on |-> !asleep);
    a_r5_req_while_awake: assert property (@(posedge clk) disable iff (!rst_n)
        checkin_req |-> !asleep);
    a_r4_pin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && pin_change) |=> (checkin_req && checkin_code == CODE_PIN));
    a_r2_timer_code: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !pin_change && sleep_exp) |=> (checkin_req && checkin_code == CODE_TIMER));
    a_r8_sleep_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_on && !asleep && sleep_cmd) |=> asleep);
    a_r7_reply_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && reply_rx && !sleep_cmd) |=> (!asleep && !checkin_req));
endmodule

// File: tb/lpw_wake_ctrl_tb.sv
module lpw_wake_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_en_n = 1'b1;
    logic tick_5s = 1'b0, tick_half = 1'b0, reply_rx = 1'b0, sleep_cmd = 1'b0;
    logic [7:0]  pins = 8'h00, wake_mask = 8'h04, wait_len = 8'd2;
    logic [15:0] sleep_len = 16'd3;
    logic asleep, checkin_req;
    logic [7:0] checkin_code;

    int total = 0, bad = 0, cycles = 0;
    string cur = "R1";
    bit started = 0;

    always #5 clk = ~clk;

    lpw_wake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lp_en_n(lp_en_n), .tick_5s(tick_5s),
        .tick_half(tick_half), .pins(pins), .wake_mask(wake_mask),
        .sleep_len(sleep_len), .wait_len(wait_len), .reply_rx(reply_rx),
        .sleep_cmd(sleep_cmd), .asleep(asleep), .checkin_req(checkin_req),
        .checkin_code(checkin_code)
    );

    // Behavioural reference model: 0 full, 1 sleep, 2 wait1, 3 wait2, 4 held.
    int   m_st = 0, m_scnt = 0, m_wcnt = 0;
    bit   m_req = 0;
    logic [7:0] m_code = 8'h00, m_ref = 8'h00;
    logic [7:0] dly[$];
    initial dly = '{8'h00, 8'h00};

    always @(posedge clk) begin
        logic [7:0] seen;
        bit chg, sx, wx, back;
        int wl;
        seen = dly[0];
        if (!rst_n) begin
            m_st = lp_en_n ? 0 : 1;
            m_scnt = sleep_len; m_wcnt = wait_len; m_ref = seen;
            m_req = 0; m_code = 8'h00;
        end else begin
            chg  = ((seen ^ m_ref) & wake_mask) != 0;
            sx   = tick_5s && (m_scnt <= 1);
            wx   = tick_half && (m_wcnt <= 1);
            wl   = wait_len;
            back = 0; m_req = 0;
            case (m_st)
                1: if (chg) begin m_st = 2; m_req = 1; m_code = 8'hC1; m_wcnt = wl; end
                   else if (sx) begin m_st = 2; m_req = 1; m_code = 8'hC2; m_wcnt = wl; end
                   else if (tick_5s) m_scnt--;
                2: if (sleep_cmd) back = 1;
                   else if (reply_rx) m_st = 4;
                   else if (wx) begin m_st = 3; m_req = 1; m_wcnt = wl; end
                   else if (tick_half) m_wcnt--;
                3: if (sleep_cmd || (!reply_rx && wx)) back = 1;
                   else if (reply_rx) m_st = 4;
                   else if (tick_half) m_wcnt--;
                4: if (sleep_cmd) back = 1;
                default: ;
            endcase
            if (back) begin m_st = 1; m_scnt = sleep_len; m_ref = seen; end
        end
        void'(dly.pop_front());
        dly.push_back(pins);
    end

    // Compare against the model between edges on every cycle.
    always @(negedge clk) begin
        if (started) begin
            total++;
            if (asleep !== (m_st == 1) || checkin_req !== m_req || checkin_code !== m_code) begin
                bad++;
                $display("FAIL %s model: got asleep=%0b req=%0b code=%h exp asleep=%0b req=%0b code=%h",
                         cur, asleep, checkin_req, checkin_code, (m_st == 1), m_req, m_code);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #3; end
    endtask
    task automatic p5();   tick_5s = 1;   step(); tick_5s = 0;   endtask
    task automatic ph();   tick_half = 1; step(); tick_half = 0; endtask
    task automatic pcmd(); sleep_cmd = 1; step(); sleep_cmd = 0; endtask
    task automatic prep(); reply_rx = 1;  step(); reply_rx = 0;  endtask
    task automatic chk(string r, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", r, got, exp);
        end
    endtask

    initial begin
        // R1: disabled mode ignores everything.
        step(3); rst_n = 1; started = 1; step();
        chk("R1 disabled awake", asleep, 0);
        pins = 8'hFF; pcmd(); p5(); p5(); p5(); ph(); step(4);
        chk("R1 disabled no sleep", asleep, 0);
        chk("R1 disabled no req", checkin_req, 0);
        // R1: enabled reset enters sleep.
        pins = 8'h00; lp_en_n = 0; rst_n = 0; step(3); rst_n = 1; step();
        chk("R1 enabled asleep", asleep, 1);
        // R2: timer wake.
        cur = "R2"; p5(); step(); p5(); chk("R2 not yet", asleep, 1);
        p5(); chk("R2 req", checkin_req, 1); chk("R2 code", checkin_code, 8'hC2);
        cur = "R5"; step(); chk("R5 pulse ends", checkin_req, 0); chk("R5 awake", asleep, 0);
        // R7: reply holds awake.
        cur = "R7"; prep(); ph(); ph(); ph(); ph(); step(2);
        chk("R7 held awake", asleep, 0);
        // R8: sleep command.
        cur = "R8"; pcmd(); chk("R8 sleep", asleep, 1);
        pcmd(); step(); chk("R8 ignored asleep", asleep, 1);
        // R3: unmasked pin ignored, masked pin wakes.
        cur = "R3"; pins[0] = 1; step(5); chk("R3 unmasked", asleep, 1);
        pins[2] = 1; step(3); chk("R3 masked req", checkin_req, 1);
        chk("R3 code", checkin_code, 8'hC1);
        // R6: retry then sleep.
        cur = "R6"; ph(); ph(); chk("R6 retry req", checkin_req, 1);
        chk("R6 retry code", checkin_code, 8'hC1);
        ph(); ph(); chk("R6 back asleep", asleep, 1);
        // R9: count restarts at each entry.
        cur = "R9"; p5(); p5(); pins[2] = 0; step(3);
        chk("R9 pin wake", checkin_req, 1);
        pcmd(); p5(); p5(); chk("R9 full length", asleep, 1);
        p5(); chk("R9 timer code", checkin_code, 8'hC2);
        // R4: same-cycle pin change and expiry.
        cur = "R4"; pcmd(); p5(); p5(); pins[2] = 1; step(2); p5();
        chk("R4 pin priority", checkin_code, 8'hC1);
        // R3: bit 7 maps to A6.
        cur = "R3"; pcmd(); wake_mask = 8'h80; pins[7] = 0; step(3);
        pins[2] = 0; step(4); chk("R3 bit2 now unmasked", asleep, 1);
        pins[7] = 1; step(3); chk("R3 bit7 wake", checkin_req, 1);
        // R6: zero wait acts as one.
        cur = "R6"; pcmd(); wait_len = 8'd0; pins[7] = 0; step(3);
        chk("R6 zero wait wake", checkin_req, 1);
        ph(); chk("R6 zero wait retry", checkin_req, 1);
        ph(); chk("R6 zero wait sleep", asleep, 1);
        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule